// File: doc/BRIEF.md
# Configurable SPI Master Byte Shift Engine

This block runs the master side of an 8-bit, full-duplex SPI byte exchange. A host write to the data buffer starts the transfer at once; there is no separate start command. The engine drives the serial clock and shifts the outgoing byte most significant bit first. It samples the incoming line at the same time, so after the last bit the received byte replaces the buffer contents. A sticky interrupt flag is then raised.

Configuration inputs control four things. One sets the idle level of the serial clock. One sets the data phase, that is, whether the first bit is presented before the first clock edge or on it. One sets the input sample point, either mid-bit or end-of-bit. The last picks one of four bit-rate sources: the system clock divided by 4, 16 or 64, or an external timer pulse train divided by two. When the output enable is low, the data output is held low, but bytes are still received and delivered in the usual way. This lets the block act as a receive-only line monitor. A buffer-full bit, an interrupt flag and a write-collision flag give the host its status. Each of these has its own clear input.

Top module: `spi_xfer_engine`

## Requirements
- R1: Bits leave on `sdo` most significant first, and the slave's byte, sampled on `sdi`, appears unchanged on `rx_data` when the transfer finishes. Both directions run in the same transfer.
- R2: A write (`wr_en` high for one cycle) while idle starts a transfer, and `busy` is high from the next cycle on. No other input starts one.
- R3: For `cfg_rate` 0, 1 and 2 the bit period is 4, 16 or 64 clock cycles. Successive active-going `sck` edges lie exactly that far apart. `irq_flag` rises 8 bit periods after the write edge.
- R4: For `cfg_rate` 3, each `tmr_pulse` seen while busy advances half a bit. The transfer completes on the 16th such pulse.
- R5: While no transfer runs, `sck` equals `cfg_cpol` (0 = idle low, 1 = idle high), including before the first transfer and between transfers.
- R6: With `cfg_cke` = 1, `sdo` carries bit 7 in the cycle after the write while `sck` is still idle, and the first clock edge falls mid-bit. With `cfg_cke` = 0, `sck` leaves its idle level in that same cycle, and data changes on that edge.
- R7: With `cfg_smp` = 0, `sdi` is sampled at the middle of each bit time. With `cfg_smp` = 1, it is sampled at the end.
- R8: On the clock edge that ends a transfer, `busy` falls, `rx_data` is loaded, and both `buf_full` and `irq_flag` are set.
- R9: With `sdo_en` low, `sdo` stays 0 for the whole transfer. Reception, `rx_data`, `buf_full` and `irq_flag` still behave as in R1 and R8.
- R10: `buf_full` clears one cycle after a `rd_en` pulse. `irq_flag` is not affected by `rd_en` and stays set until an `irq_clr` pulse.
- R11: A write while busy is ignored by the transfer in progress and sets `wcol`. `wcol` stays set until a `wcol_clr` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cke | input | 1 | 1: data valid before first clock edge; 0: data changes on first edge |
| cfg_smp | input | 1 | 0: sample mid-bit; 1: sample end of bit |
| cfg_rate | input | 2 | 0: clk/4, 1: clk/16, 2: clk/64, 3: timer pulse / 2 |
| sdo_en | input | 1 | Data output enable (0 = receive-only) |
| tmr_pulse | input | 1 | One-cycle pulses from an external timer |
| wr_en | input | 1 | Buffer write strobe, starts a transfer |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Host buffer read strobe, clears buffer-full |
| irq_clr | input | 1 | Clears the interrupt flag |
| wcol_clr | input | 1 | Clears the write-collision flag |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| rx_data | output | 8 | Received byte buffer |
| busy | output | 1 | Transfer in progress |
| buf_full | output | 1 | Received byte waiting |
| irq_flag | output | 1 | Transfer complete, sticky |
| wcol | output | 1 | Write while busy, sticky |

## Verification
The write edge is taken as cycle 0. `busy`, the first `sdo` bit and the first `sck` level are due in cycle 1. For divider rates, completion and both flags are due exactly 8·DIV cycles after the write. Every clear takes effect one cycle after its pulse. The bench drives inputs on the falling clock edge and counts falling edges from the write, so each result is compared at its exact cycle rather than waited for. The serial clock is sampled one nanosecond after each rising edge; from that, the bench measures active-edge spacing and runs an edge-counting slave model for all polarity, phase and sample combinations.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef enum logic [1:0] {
    RATE_DIV_FAST = 2'd0,
    RATE_DIV_MID  = 2'd1,
    RATE_DIV_SLOW = 2'd2,
    RATE_TIMER    = 2'd3
  } rate_e;

  typedef struct packed {
    logic  cpol;
    logic  cke;
    logic  smp;
    rate_e rate;
  } link_cfg_t;

  // half-bit reload value for a system-clock divider
  function automatic int half_limit(input int div);
    return (div / 2) - 1;
  endfunction

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_eng_pkg::*;
#(
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  rate_e rate,
  input  logic  tmr_pulse,
  output logic  tick
);

  localparam int CW = $clog2(DIV_SLOW / 2) + 1;
  localparam logic [CW-1:0] LIM_FAST = CW'(half_limit(DIV_FAST));
  localparam logic [CW-1:0] LIM_MID  = CW'(half_limit(DIV_MID));
  localparam logic [CW-1:0] LIM_SLOW = CW'(half_limit(DIV_SLOW));

  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] lim;
  logic          wrap;

  always_comb begin
    unique case (rate)
      RATE_DIV_FAST: lim = LIM_FAST;
      RATE_DIV_MID:  lim = LIM_MID;
      RATE_DIV_SLOW: lim = LIM_SLOW;
      default:       lim = LIM_FAST;
    endcase
  end

  assign wrap = (cnt_q == lim);

  always_comb begin
    cnt_n = cnt_q;
    if (!run) begin
      cnt_n = '0;
    end else if (wrap) begin
      cnt_n = '0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign tick = run && ((rate == RATE_TIMER) ? tmr_pulse : wrap);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rate != RATE_TIMER && tick) |=> !tick); // R3

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] tx_byte,
  input  logic          tick,
  input  logic          smp,
  input  logic          sdi,
  output logic          busy,
  output logic          half_b,
  output logic          out_bit,
  output logic          fin,
  output logic [DW-1:0] rx_byte
);

  localparam int            NHALF = 2 * DW;
  localparam int            HW    = $clog2(NHALF);
  localparam logic [HW-1:0] LAST  = HW'(NHALF - 1);

  logic          busy_q, busy_n;
  logic [HW-1:0] hph_q, hph_n;
  logic [DW-1:0] sh_q, sh_n;
  logic [DW-1:0] rx_q, rx_n;
  logic          mid_q, mid_n;
  logic          in_bit;

  assign in_bit = smp ? sdi : mid_q;

  always_comb begin
    busy_n = busy_q;
    hph_n  = hph_q;
    sh_n   = sh_q;
    rx_n   = rx_q;
    mid_n  = mid_q;
    fin    = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_n = 1'b1;
        hph_n  = '0;
        sh_n   = tx_byte;
        mid_n  = 1'b0;
      end
    end else if (tick) begin
      if (!hph_q[0]) begin
        // middle of the bit time
        if (!smp) begin
          mid_n = sdi;
        end
        hph_n = hph_q + 1'b1;
      end else begin
        // end of the bit time
        sh_n = {sh_q[DW-2:0], in_bit};
        if (hph_q == LAST) begin
          busy_n = 1'b0;
          fin    = 1'b1;
          rx_n   = {sh_q[DW-2:0], in_bit};
        end else begin
          hph_n = hph_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hph_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      mid_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      hph_q  <= hph_n;
      sh_q   <= sh_n;
      rx_q   <= rx_n;
      mid_q  <= mid_n;
    end
  end

  assign busy    = busy_q;
  assign half_b  = hph_q[0];
  assign out_bit = sh_q[DW-1];
  assign rx_byte = rx_q;

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> $stable(hph_q)); // R3

endmodule

// File: rtl/spi_pin_drive.sv
module spi_pin_drive (
  input  logic busy,
  input  logic half_b,
  input  logic out_bit,
  input  logic cpol,
  input  logic cke,
  input  logic oe,
  output logic sck,
  output logic sdo
);

  logic active;

  // cke=1: first half idle, second half active; cke=0: the reverse
  assign active = busy && (cke ? half_b : !half_b);
  assign sck    = cpol ^ active;
  assign sdo    = oe && out_bit;

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_cpol,
  input  logic          cfg_cke,
  input  logic          cfg_smp,
  input  logic [1:0]    cfg_rate,
  input  logic          sdo_en,
  input  logic          tmr_pulse,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          irq_clr,
  input  logic          wcol_clr,
  input  logic          sdi,
  output logic          sck,
  output logic          sdo,
  output logic [DW-1:0] rx_data,
  output logic          busy,
  output logic          buf_full,
  output logic          irq_flag,
  output logic          wcol
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_ns = rst_pipe_q[1];

  link_cfg_t cfg;
  assign cfg.cpol = cfg_cpol;
  assign cfg.cke  = cfg_cke;
  assign cfg.smp  = cfg_smp;
  assign cfg.rate = rate_e'(cfg_rate);

  logic tick, fin, half_b, out_bit, busy_i;
  logic start;

  assign start = wr_en && !busy_i;

  spi_rate_gen #(
    .DIV_FAST (DIV_FAST),
    .DIV_MID  (DIV_MID),
    .DIV_SLOW (DIV_SLOW)
  ) u_rate (
    .clk       (clk),
    .rst_n     (rst_ns),
    .run       (busy_i),
    .rate      (cfg.rate),
    .tmr_pulse (tmr_pulse),
    .tick      (tick)
  );

  spi_shift_core #(
    .DW (DW)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_ns),
    .start   (start),
    .tx_byte (wr_data),
    .tick    (tick),
    .smp     (cfg.smp),
    .sdi     (sdi),
    .busy    (busy_i),
    .half_b  (half_b),
    .out_bit (out_bit),
    .fin     (fin),
    .rx_byte (rx_data)
  );

  spi_pin_drive u_pins (
    .busy    (busy_i),
    .half_b  (half_b),
    .out_bit (out_bit),
    .cpol    (cfg.cpol),
    .cke     (cfg.cke),
    .oe      (sdo_en),
    .sck     (sck),
    .sdo     (sdo)
  );

  // host status flags
  logic full_q, full_n;
  logic irq_q, irq_n;
  logic wcol_q, wcol_n;

  always_comb begin
    full_n = full_q;
    irq_n  = irq_q;
    wcol_n = wcol_q;
    if (fin) begin
      full_n = 1'b1;
    end else if (rd_en) begin
      full_n = 1'b0;
    end
    if (fin) begin
      irq_n = 1'b1;
    end else if (irq_clr) begin
      irq_n = 1'b0;
    end
    if (wr_en && busy_i) begin
      wcol_n = 1'b1;
    end else if (wcol_clr) begin
      wcol_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      full_q <= 1'b0;
      irq_q  <= 1'b0;
      wcol_q <= 1'b0;
    end else begin
      full_q <= full_n;
      irq_q  <= irq_n;
      wcol_q <= wcol_n;
    end
  end

  assign busy     = busy_i;
  assign buf_full = full_q;
  assign irq_flag = irq_q;
  assign wcol     = wcol_q;

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && !busy) |=> busy); // R2
  AST_WCOL_RAISE: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && busy) |=> wcol); // R11
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(busy) |-> (irq_flag && buf_full)); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_ns)
    (irq_flag && !irq_clr) |=> irq_flag); // R10
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_ns)
    (!busy && $stable(cfg_cpol)) |-> (sck == cfg_cpol)); // R5

endmodule

// File: tb/sim_spi_xfer_engine.sv
module sim_spi_xfer_engine;

  logic       clk = 1'b0;
  logic       rst_n, cpol, cke, smp, sdo_en, tmr_pulse, sdi;
  logic       wr_en, rd_en, irq_clr, wcol_clr;
  logic [1:0] rate;
  logic [7:0] wr_data, rx_data;
  logic       sck, sdo, busy, buf_full, irq_flag, wcol;

  always #2 clk = ~clk;

  spi_xfer_engine u0 (
    .clk (clk), .rst_n (rst_n), .cfg_cpol (cpol), .cfg_cke (cke),
    .cfg_smp (smp), .cfg_rate (rate), .sdo_en (sdo_en),
    .tmr_pulse (tmr_pulse), .wr_en (wr_en), .wr_data (wr_data),
    .rd_en (rd_en), .irq_clr (irq_clr), .wcol_clr (wcol_clr), .sdi (sdi),
    .sck (sck), .sdo (sdo), .rx_data (rx_data), .busy (busy),
    .buf_full (buf_full), .irq_flag (irq_flag), .wcol (wcol)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model and timer source, evaluated 1 ns after each rising edge
  int         mcyc = 0, e_cnt = 0, act1 = -1, act2 = -1, tdiv = 0, tmr_seen = 0;
  logic       psck = 1'b0;
  logic [7:0] slv_out = 8'h00, slv_in = 8'h00;
  bit         smode = 1'b0, tmr_on = 1'b0, sdo_bad = 1'b0;

  always @(posedge clk) begin
    int idx;
    #1;
    mcyc++;
    if (tmr_on) begin
      if (tdiv == 4) begin
        tdiv = 0;
        tmr_pulse = 1'b1;
        if (busy) tmr_seen++;
      end else begin
        tdiv++;
        tmr_pulse = 1'b0;
      end
    end else begin
      tmr_pulse = 1'b0;
    end
    if (busy && !sdo_en && sdo) sdo_bad = 1'b1;
    if (sck != psck) begin
      e_cnt++;
      if (psck == cpol) begin
        if (act1 < 0) act1 = mcyc;
        else if (act2 < 0) act2 = mcyc;
      end
      if (cke ? (e_cnt % 2 == 1) : (e_cnt % 2 == 0)) slv_in = {slv_in[6:0], sdo};
    end
    psck = sck;
    idx = cke ? e_cnt / 2 : ((e_cnt == 0) ? 0 : (e_cnt - 1) / 2);
    if (idx > 7) idx = 7;
    sdi = smode ? (sck == cpol) : slv_out[7 - idx];
  end

  task automatic xfer(input logic [7:0] tx, input logic [7:0] slv,
                      input bit p, input bit e, input bit s, input int r,
                      input bit oe, input bit m, input bit coll);
    int   k;
    int   h;
    logic [7:0] exp_rx;
    h = (r == 0) ? 2 : (r == 1) ? 8 : 32;
    @(negedge clk);
    cpol = p; cke = e; smp = s; rate = 2'(r); sdo_en = oe;
    smode = m; slv_out = slv; tmr_on = (r == 3);
    @(negedge clk);
    chk_eq("R5 idle sck before start", sck, p);
    e_cnt = 0; act1 = -1; act2 = -1; psck = p; slv_in = 8'h00;
    tmr_seen = 0; sdo_bad = 1'b0;
    sdi = m ? 1'b1 : slv[7];
    wr_data = tx; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; k = 0;
    chk_eq("R2 busy after write", busy, 1);
    chk_eq("R6 first sck level", sck, e ? p : !p);
    chk_eq("R6 first sdo bit", sdo, oe ? tx[7] : 1'b0);
    if (coll) begin
      @(negedge clk); k++;
      wr_data = ~tx; wr_en = 1'b1;
      @(negedge clk); k++;
      wr_en = 1'b0;
      chk_eq("R11 wcol on busy write", wcol, 1);
    end
    while (!irq_flag && k < 5000) begin
      @(negedge clk); k++;
    end
    if (r != 3) begin
      chk_eq("R3 completion cycle", k, 16 * h);
      chk_eq("R3 sck period", act2 - act1, 2 * h);
    end else begin
      chk_eq("R4 timer pulses per byte", tmr_seen, 16);
    end
    if (m) exp_rx = e ? (s ? 8'h00 : 8'hFF) : (s ? 8'hFF : 8'h00);
    else   exp_rx = slv;
    chk_eq(m ? "R7 sample point" : "R1 received byte", rx_data, exp_rx);
    if (oe && !m) chk_eq("R1 slave got byte", slv_in, tx);
    if (!oe) chk_eq("R9 sdo held low", sdo_bad, 0);
    chk_eq("R8 buf_full at done", buf_full, 1);
    chk_eq("R8 busy fell", busy, 0);
    chk_eq("R5 sck idle after", sck, p);
    repeat (3) @(negedge clk);
    chk_eq("R10 irq sticky", irq_flag, 1);
    rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk_eq("R10 buf_full cleared", buf_full, 0);
    chk_eq("R10 irq kept on read", irq_flag, 1);
    irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk_eq("R10 irq cleared", irq_flag, 0);
    if (coll) begin
      chk_eq("R11 wcol sticky", wcol, 1);
      wcol_clr = 1'b1;
      @(negedge clk); wcol_clr = 1'b0;
      chk_eq("R11 wcol cleared", wcol, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; cpol = 1'b0; cke = 1'b0; smp = 1'b0; rate = 2'd0;
    sdo_en = 1'b1; tmr_pulse = 1'b0; sdi = 1'b0; wr_en = 1'b0;
    wr_data = 8'h00; rd_en = 1'b0; irq_clr = 1'b0; wcol_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_eq("R5 reset sck", sck, 0);
    chk_eq("R2 reset busy", busy, 0);
    chk_eq("R8 reset flags", {buf_full, irq_flag, wcol}, 0);

    // all clock modes and sample points, fastest divider, slave model
    for (int p = 0; p < 2; p++) begin
      for (int e = 0; e < 2; e++) begin
        for (int s = 0; s < 2; s++) begin
          xfer(8'(8'h96 ^ (p << 5) ^ (e << 2) ^ s), 8'(8'h5B + 17 * (4 * p + 2 * e + s)),
               p[0], e[0], s[0], 0, 1'b1, 1'b0, 1'b0);
        end
      end
    end
    // slower dividers and timer source
    xfer(8'hC3, 8'h81, 1'b0, 1'b1, 1'b0, 1, 1'b1, 1'b0, 1'b0);
    xfer(8'h18, 8'h7E, 1'b1, 1'b0, 1'b1, 2, 1'b1, 1'b0, 1'b0);
    xfer(8'hE1, 8'h2D, 1'b0, 1'b0, 1'b0, 3, 1'b1, 1'b0, 1'b0);
    // receive-only
    xfer(8'hFF, 8'hA6, 1'b1, 1'b1, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    // sample point discrimination: sdi differs between the two bit halves
    for (int e = 0; e < 2; e++) begin
      for (int s = 0; s < 2; s++) begin
        xfer(8'h00, 8'h00, 1'b0, e[0], s[0], 0, 1'b0, 1'b1, 1'b0);
      end
    end
    // write collision during a transfer
    xfer(8'h4D, 8'hB2, 1'b0, 1'b1, 1'b0, 0, 1'b1, 1'b0, 1'b1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule